// File: doc/BRIEF.md
# Parallel NOR Flash Identification Probe

This engine interrogates a parallel NOR flash bank after reset and leaves a small bank descriptor on its outputs. A one-cycle `start` launches the probe. The engine first masters the flash bus to send the unlock-and-identify command cycles. It waits a settling time derived from the clock frequency, then reads the manufacturer code and the device code. From those two codes it works out which command-set family the part belongs to and whether the part is the one supported geometry. That geometry is 128 equal sectors of 64 KiB, 8 MiB in total.

When the part is recognised, the engine repeats both identification reads in a second window whose word address has one high bit set. If both codes come back the same there, the second chip-select decodes onto the same chip. The bank is then dropped as a mirror. In every case the engine ends with one exit command to the bank base, which puts the part back into array-read mode. The exit byte depends on the detected family. After that write, `done` pulses and the descriptor is final. A sector index input returns the byte offset of that sector within a valid bank.

Top module: `nor_id_probe`

## Requirements
- R1: A probe begins with three writes, each with the command byte in bits 7:0 and zeros above: 0xAA to word offset 0x555, then 0x55 to word offset 0x2AA, then 0x90 to word offset 0x555.
- R2: After the 0x90 write ends, no read strobe rises for at least WAIT_CYC = (CLK_HZ/1e6)*WAIT_US clock cycles.
- R3: The manufacturer code is bits 7:0 of the read at word offset 0, and the upper bits of that read are ignored. The device code is the full-width read at word offset 1 and is reported on `dev_code`.
- R4: If the manufacturer code is neither 0x01 nor 0x89, or the device code is not 0x0093, the bank is invalid. Then `id_valid`=0, `size_bytes`=0, `sect_count`=0 and `vendor_class`=0, and no second-window reads take place.
- R5: A recognised bank reports `id_valid`=1, `size_bytes`=8388608 and `sect_count`=128. `vendor_class` is 1 for manufacturer 0x01 (unlock-sequence family) and 2 for 0x89 (status-register family).
- R6: For a recognised part, the engine reads word offsets 0x400000 and 0x400001 after offsets 0 and 1. If bits 7:0 of the first of these equal the manufacturer code and the second equals the device code in full, the bank is reported invalid as in R4.
- R7: Every probe ends with exactly one further write to word offset 0. Its data is 0xFF when the manufacturer code is 0x89 and 0xF0 otherwise. This write completes before `done` rises.
- R8: `done` is high for exactly one cycle per probe, and the descriptor outputs carry the result in that cycle.
- R9: A start accepted while idle clears `id_valid` in the next cycle. The descriptor outputs then hold until the next accepted start. A `start` pulse during a probe is ignored.
- R10: `sect_base` gives `sect_sel`*0x10000, one cycle after `sect_sel` is applied, while `id_valid`=1. It is 0 while the bank is invalid.
- R11: Each write or read strobe stays high for exactly STROBE_CYC cycles. The two strobes are never high together.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-cycle request to probe the bank |
| done | output | 1 | One-cycle pulse when the descriptor is final |
| fl_addr | output | ADDR_W | Flash word address |
| fl_wdata | output | DATA_W | Flash write data |
| fl_rdata | input | DATA_W | Flash read data |
| fl_we | output | 1 | Write strobe |
| fl_re | output | 1 | Read strobe |
| id_valid | output | 1 | Bank recognised and not a mirror |
| vendor_class | output | 2 | 0 none, 1 unlock-sequence family, 2 status-register family |
| dev_code | output | DATA_W | Device code read at word offset 1 |
| size_bytes | output | 32 | Bank size in bytes |
| sect_count | output | $clog2(SECT_CNT+1) | Number of sectors |
| sect_sel | input | $clog2(SECT_CNT) | Sector index for the start-offset lookup |
| sect_base | output | 32 | Byte offset of the selected sector |

## Verification
The hardest case to reach is a mirror verdict that depends on only part of the second-window data. The bank must be dropped when that window differs only in the ignored upper byte of the manufacturer read. It must be kept when the window matches on the manufacturer byte but differs in the device code, or the other way round. The bench's flash model has a selectable second-window personality covering floating, exact copy, upper-byte-only difference, device difference and manufacturer difference. Random trials combine these with both command families and with unrecognised codes, so the alias reads, the exit byte and the descriptor are each exercised against every verdict.

// File: rtl/nor_probe_pkg.sv
package nor_probe_pkg;

  typedef enum logic [1:0] {
    FAM_NONE   = 2'd0,
    FAM_UNLOCK = 2'd1,
    FAM_STATUS = 2'd2
  } fam_e;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_UNL1,
    ST_UNL2,
    ST_IDCMD,
    ST_WAIT,
    ST_RMFR,
    ST_RDEV,
    ST_SORT,
    ST_AMFR,
    ST_ADEV,
    ST_EXIT
  } phase_e;

  localparam logic [7:0] CMD_UNL1        = 8'hAA;
  localparam logic [7:0] CMD_UNL2        = 8'h55;
  localparam logic [7:0] CMD_IDENT       = 8'h90;
  localparam logic [7:0] CMD_EXIT_UNLOCK = 8'hF0;
  localparam logic [7:0] CMD_EXIT_STATUS = 8'hFF;

  localparam int unsigned OFS_UNL1 = 'h555;
  localparam int unsigned OFS_UNL2 = 'h2AA;

endpackage

// File: rtl/nor_bus_cycle.sv
module nor_bus_cycle #(
  parameter int ADDR_W     = 23,
  parameter int DATA_W     = 16,
  parameter int STROBE_CYC = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              go,
  input  logic              is_wr,
  input  logic [ADDR_W-1:0] addr_in,
  input  logic [DATA_W-1:0] wdata_in,
  output logic              ack,
  output logic [DATA_W-1:0] rdata_q,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [DATA_W-1:0] bus_wdata,
  output logic              bus_we,
  output logic              bus_re,
  input  logic [DATA_W-1:0] bus_rdata
);
  localparam int CNT_W = $clog2(STROBE_CYC + 1);

  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      ack       <= 1'b0;
      rdata_q   <= '0;
      bus_addr  <= '0;
      bus_wdata <= '0;
      bus_we    <= 1'b0;
      bus_re    <= 1'b0;
      cnt       <= '0;
    end else begin
      ack <= 1'b0;
      if (go) begin
        bus_addr  <= addr_in;
        bus_wdata <= is_wr ? wdata_in : '0;
        bus_we    <= is_wr;
        bus_re    <= !is_wr;
        cnt       <= CNT_W'(STROBE_CYC);
      end else if (bus_we || bus_re) begin
        if (cnt == CNT_W'(1)) begin
          bus_we <= 1'b0;
          bus_re <= 1'b0;
          ack    <= 1'b1;
          if (bus_re) rdata_q <= bus_rdata;
        end else begin
          cnt <= cnt - CNT_W'(1);
        end
      end
    end
  end
endmodule

// File: rtl/nor_wait_timer.sv
module nor_wait_timer #(
  parameter int WAIT_CYC = 20000
) (
  input  logic clk,
  input  logic rst,
  input  logic kick,
  output logic fin
);
  localparam int CNT_W = $clog2(WAIT_CYC + 1);

  logic [CNT_W-1:0] cnt;
  logic             armed;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt   <= '0;
      armed <= 1'b0;
      fin   <= 1'b0;
    end else begin
      fin <= 1'b0;
      if (kick) begin
        cnt   <= CNT_W'(WAIT_CYC - 1);
        armed <= 1'b1;
      end else if (armed) begin
        if (cnt == '0) begin
          fin   <= 1'b1;
          armed <= 1'b0;
        end else begin
          cnt <= cnt - CNT_W'(1);
        end
      end
    end
  end
endmodule

// File: rtl/nor_id_classify.sv
module nor_id_classify
  import nor_probe_pkg::*;
#(
  parameter int          DATA_W     = 16,
  parameter logic [7:0]  MFR_UNLOCK = 8'h01,
  parameter logic [7:0]  MFR_STATUS = 8'h89,
  parameter int unsigned DEV_CODE   = 'h0093
) (
  input  logic [7:0]        mfr,
  input  logic [DATA_W-1:0] dev,
  output fam_e              fam,
  output logic              known
);
  always_comb begin
    if (mfr == MFR_STATUS)      fam = FAM_STATUS;
    else if (mfr == MFR_UNLOCK) fam = FAM_UNLOCK;
    else                        fam = FAM_NONE;
    known = (fam != FAM_NONE) && (dev == DATA_W'(DEV_CODE));
  end
endmodule

// File: rtl/nor_id_probe.sv
module nor_id_probe
  import nor_probe_pkg::*;
#(
  parameter int          ADDR_W     = 23,
  parameter int          DATA_W     = 16,
  parameter int          CLK_HZ     = 200_000_000,
  parameter int          WAIT_US    = 100,
  parameter int          STROBE_CYC = 3,
  parameter int          ALIAS_BIT  = 22,
  parameter logic [7:0]  MFR_UNLOCK = 8'h01,
  parameter logic [7:0]  MFR_STATUS = 8'h89,
  parameter int unsigned DEV_CODE   = 'h0093,
  parameter int          SECT_CNT   = 128,
  parameter int          SECT_BYTES = 65536,
  localparam int         SEL_W      = $clog2(SECT_CNT),
  localparam int         CNT_W      = $clog2(SECT_CNT + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  output logic              done,
  output logic [ADDR_W-1:0] fl_addr,
  output logic [DATA_W-1:0] fl_wdata,
  input  logic [DATA_W-1:0] fl_rdata,
  output logic              fl_we,
  output logic              fl_re,
  output logic              id_valid,
  output logic [1:0]        vendor_class,
  output logic [DATA_W-1:0] dev_code,
  output logic [31:0]       size_bytes,
  output logic [CNT_W-1:0]  sect_count,
  input  logic [SEL_W-1:0]  sect_sel,
  output logic [31:0]       sect_base
);
  localparam int WAIT_RAW   = (CLK_HZ / 1_000_000) * WAIT_US;
  localparam int WAIT_CYC   = (WAIT_RAW < 1) ? 1 : WAIT_RAW;
  localparam int SIZE_BYTES = SECT_CNT * SECT_BYTES;
  localparam logic [ADDR_W-1:0] ALIAS_OFS = ADDR_W'(1) << ALIAS_BIT;

  phase_e            state;
  logic              pend;
  logic [7:0]        mfr_q, amfr_q;
  logic [DATA_W-1:0] dev_q;
  logic              mirror_q;

  logic              go, is_wr, ack, wait_fin, known, on_bus;
  logic [ADDR_W-1:0] cyc_addr;
  logic [7:0]        cyc_cmd;
  logic [DATA_W-1:0] rd_q;
  fam_e              fam;

  nor_id_classify #(
    .DATA_W(DATA_W), .MFR_UNLOCK(MFR_UNLOCK),
    .MFR_STATUS(MFR_STATUS), .DEV_CODE(DEV_CODE)
  ) u_class (
    .mfr(mfr_q), .dev(dev_q), .fam(fam), .known(known)
  );

  // Cycle request decoded from the phase
  always_comb begin
    on_bus   = 1'b1;
    is_wr    = 1'b0;
    cyc_addr = '0;
    cyc_cmd  = '0;
    unique case (state)
      ST_UNL1:  begin is_wr = 1'b1; cyc_addr = ADDR_W'(OFS_UNL1); cyc_cmd = CMD_UNL1;  end
      ST_UNL2:  begin is_wr = 1'b1; cyc_addr = ADDR_W'(OFS_UNL2); cyc_cmd = CMD_UNL2;  end
      ST_IDCMD: begin is_wr = 1'b1; cyc_addr = ADDR_W'(OFS_UNL1); cyc_cmd = CMD_IDENT; end
      ST_RMFR:  cyc_addr = '0;
      ST_RDEV:  cyc_addr = ADDR_W'(1);
      ST_AMFR:  cyc_addr = ALIAS_OFS;
      ST_ADEV:  cyc_addr = ALIAS_OFS | ADDR_W'(1);
      ST_EXIT:  begin
        is_wr   = 1'b1;
        cyc_cmd = (fam == FAM_STATUS) ? CMD_EXIT_STATUS : CMD_EXIT_UNLOCK;
      end
      default:  on_bus = 1'b0;
    endcase
    go = on_bus && !pend;
  end

  nor_bus_cycle #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .STROBE_CYC(STROBE_CYC)
  ) u_bus (
    .clk(clk), .rst(rst), .go(go), .is_wr(is_wr),
    .addr_in(cyc_addr), .wdata_in(DATA_W'(cyc_cmd)),
    .ack(ack), .rdata_q(rd_q),
    .bus_addr(fl_addr), .bus_wdata(fl_wdata),
    .bus_we(fl_we), .bus_re(fl_re), .bus_rdata(fl_rdata)
  );

  nor_wait_timer #(.WAIT_CYC(WAIT_CYC)) u_wait (
    .clk(clk), .rst(rst), .kick(state == ST_IDCMD && ack), .fin(wait_fin)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state        <= ST_IDLE;
      pend         <= 1'b0;
      mfr_q        <= '0;
      amfr_q       <= '0;
      dev_q        <= '0;
      mirror_q     <= 1'b0;
      done         <= 1'b0;
      id_valid     <= 1'b0;
      vendor_class <= FAM_NONE;
      dev_code     <= '0;
      size_bytes   <= '0;
      sect_count   <= '0;
    end else begin
      done <= 1'b0;
      if (go) pend <= 1'b1;
      if (ack) pend <= 1'b0;
      unique case (state)
        ST_IDLE: if (start) begin
          state        <= ST_UNL1;
          mirror_q     <= 1'b0;
          id_valid     <= 1'b0;
          vendor_class <= FAM_NONE;
          dev_code     <= '0;
          size_bytes   <= '0;
          sect_count   <= '0;
        end
        ST_UNL1:  if (ack) state <= ST_UNL2;
        ST_UNL2:  if (ack) state <= ST_IDCMD;
        ST_IDCMD: if (ack) state <= ST_WAIT;
        ST_WAIT:  if (wait_fin) state <= ST_RMFR;
        ST_RMFR:  if (ack) begin mfr_q <= rd_q[7:0]; state <= ST_RDEV; end
        ST_RDEV:  if (ack) begin dev_q <= rd_q;      state <= ST_SORT; end
        ST_SORT:  state <= known ? ST_AMFR : ST_EXIT;
        ST_AMFR:  if (ack) begin amfr_q <= rd_q[7:0]; state <= ST_ADEV; end
        ST_ADEV:  if (ack) begin
          mirror_q <= (amfr_q == mfr_q) && (rd_q == dev_q);
          state    <= ST_EXIT;
        end
        ST_EXIT:  if (ack) begin
          done         <= 1'b1;
          state        <= ST_IDLE;
          id_valid     <= known && !mirror_q;
          vendor_class <= (known && !mirror_q) ? fam : FAM_NONE;
          dev_code     <= dev_q;
          size_bytes   <= (known && !mirror_q) ? 32'(SIZE_BYTES) : '0;
          sect_count   <= (known && !mirror_q) ? CNT_W'(SECT_CNT) : '0;
        end
        default:  state <= ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) sect_base <= '0;
    else if (id_valid && (32'(sect_sel) < 32'(SECT_CNT)))
      sect_base <= 32'(sect_sel) * 32'(SECT_BYTES);
    else sect_base <= '0;
  end
endmodule

// File: rtl/nor_id_probe_chk.sv
module nor_id_probe_chk #(
  parameter int DATA_W     = 16,
  parameter int CNT_W      = 8,
  parameter int STROBE_CYC = 3,
  parameter int WAIT_CYC   = 20000,
  parameter int SIZE_BYTES = 8388608,
  parameter int SECT_CNT   = 128
) (
  input logic              clk,
  input logic              rst,
  input logic              start,
  input logic              done,
  input logic              fl_we,
  input logic              fl_re,
  input logic [DATA_W-1:0] fl_wdata,
  input logic              id_valid,
  input logic [1:0]        vendor_class,
  input logic [31:0]       size_bytes,
  input logic [CNT_W-1:0]  sect_count
);
  localparam int GAP_W = $clog2(WAIT_CYC + 1) + 1;
  localparam int STB_W = $clog2(STROBE_CYC + 1) + 1;

  logic [STB_W-1:0] stb_cnt;
  logic [GAP_W-1:0] gap;
  logic             armed;

  always_ff @(posedge clk) begin
    if (rst) begin
      stb_cnt <= '0;
      gap     <= '0;
      armed   <= 1'b0;
    end else begin
      if (fl_we || fl_re) stb_cnt <= stb_cnt + STB_W'(1);
      else                stb_cnt <= '0;
      if (fl_we && fl_wdata[7:0] == 8'h90) begin
        armed <= 1'b1;
        gap   <= '0;
      end else if (fl_re) begin
        armed <= 1'b0;
      end else if (armed && gap < GAP_W'(WAIT_CYC)) begin
        gap <= gap + GAP_W'(1);
      end
    end
  end

  AST_WAIT_BEFORE_READ: assert property (@(posedge clk) disable iff (rst)
    ($rose(fl_re) && armed) |-> gap >= GAP_W'(WAIT_CYC)); // R2
  AST_WE_WIDTH: assert property (@(posedge clk) disable iff (rst)
    $fell(fl_we) |-> stb_cnt == STB_W'(STROBE_CYC)); // R11
  AST_RE_WIDTH: assert property (@(posedge clk) disable iff (rst)
    $fell(fl_re) |-> stb_cnt == STB_W'(STROBE_CYC)); // R11
  AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (rst)
    !(fl_we && fl_re)); // R11
  AST_INVALID_ZERO: assert property (@(posedge clk) disable iff (rst)
    (done && !id_valid) |-> (size_bytes == '0 && sect_count == '0 && vendor_class == 2'd0)); // R4
  AST_VALID_GEOM: assert property (@(posedge clk) disable iff (rst)
    id_valid |-> (size_bytes == 32'(SIZE_BYTES) && sect_count == CNT_W'(SECT_CNT) && vendor_class != 2'd0)); // R5
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
    done |=> !done); // R8
  AST_DESC_HOLD: assert property (@(posedge clk) disable iff (rst)
    (id_valid != $past(id_valid)) |-> (done || $past(start))); // R9
endmodule

bind nor_id_probe nor_id_probe_chk #(
  .DATA_W(DATA_W), .CNT_W(CNT_W), .STROBE_CYC(STROBE_CYC),
  .WAIT_CYC(WAIT_CYC), .SIZE_BYTES(SIZE_BYTES), .SECT_CNT(SECT_CNT)
) u_chk (
  .clk(clk), .rst(rst), .start(start), .done(done),
  .fl_we(fl_we), .fl_re(fl_re), .fl_wdata(fl_wdata),
  .id_valid(id_valid), .vendor_class(vendor_class),
  .size_bytes(size_bytes), .sect_count(sect_count)
);

// File: tb/nor_id_probe_test.sv
module nor_id_probe_test;
  localparam int HALF     = 2500;   // ps with the default 1ps unit: 200 MHz
  localparam int ADDR_W   = 23;
  localparam int DATA_W   = 16;
  localparam int STROBE   = 3;
  localparam int WAIT_US  = 2;
  localparam int WAIT_CYC = 200 * WAIT_US;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              start = 1'b0;
  logic              done, fl_we, fl_re, id_valid;
  logic [ADDR_W-1:0] fl_addr;
  logic [DATA_W-1:0] fl_wdata, fl_rdata, dev_code;
  logic [1:0]        vendor_class;
  logic [31:0]       size_bytes, sect_base;
  logic [7:0]        sect_count;
  logic [6:0]        sect_sel = '0;

  always #HALF clk = ~clk;

  nor_id_probe #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CLK_HZ(200_000_000),
    .WAIT_US(WAIT_US), .STROBE_CYC(STROBE)
  ) uut (
    .clk(clk), .rst(rst), .start(start), .done(done),
    .fl_addr(fl_addr), .fl_wdata(fl_wdata), .fl_rdata(fl_rdata),
    .fl_we(fl_we), .fl_re(fl_re), .id_valid(id_valid),
    .vendor_class(vendor_class), .dev_code(dev_code),
    .size_bytes(size_bytes), .sect_count(sect_count),
    .sect_sel(sect_sel), .sect_base(sect_base)
  );

  // Flash model: alias personalities 0 floating, 1 copy, 2 device differs,
  // 3 manufacturer byte differs, 4 only upper bits of word 0 differ
  logic [15:0] m_mfr = '0, m_dev = '0;
  int          m_alias = 0;
  logic        m_id = 1'b0;
  int          m_stage = 0;

  always_comb begin
    fl_rdata = 16'hFFFF;
    if (m_id) begin
      if (fl_addr[22] && m_alias == 0) fl_rdata = 16'hFFFF;
      else if (fl_addr[21:0] == 22'd0) begin
        fl_rdata = m_mfr;
        if (fl_addr[22] && m_alias == 3) fl_rdata = m_mfr ^ 16'h0040;
        if (fl_addr[22] && m_alias == 4) fl_rdata = m_mfr ^ 16'hA500;
      end else if (fl_addr[21:0] == 22'd1) begin
        fl_rdata = m_dev;
        if (fl_addr[22] && m_alias == 2) fl_rdata = m_dev ^ 16'h0100;
      end
    end
  end

  // Bus monitor
  logic              clr = 1'b0;
  logic              we_d = 1'b0, re_d = 1'b0;
  logic [ADDR_W-1:0] wlog_a [8];
  logic [15:0]       wlog_d [8];
  logic [ADDR_W-1:0] rlog_a [8];
  int wn = 0, rn = 0, cyc = 0, t_fall = 0, gap = 0;

  always @(posedge clk) begin
    cyc  <= cyc + 1;
    we_d <= fl_we;
    re_d <= fl_re;
    if (we_d && !fl_we) t_fall <= cyc;
    if (clr) begin
      wn <= 0; rn <= 0;
    end else begin
      if (fl_we && !we_d) begin
        if (wn < 8) begin wlog_a[wn] <= fl_addr; wlog_d[wn] <= fl_wdata; end
        wn <= wn + 1;
        if (fl_addr == 23'h555 && fl_wdata[7:0] == 8'hAA) m_stage <= 1;
        else if (m_stage == 1 && fl_addr == 23'h2AA && fl_wdata[7:0] == 8'h55) m_stage <= 2;
        else if (m_stage == 2 && fl_addr == 23'h555 && fl_wdata[7:0] == 8'h90) begin
          m_id <= 1'b1; m_stage <= 0;
        end else m_stage <= 0;
        if (fl_wdata[7:0] == 8'hF0 || fl_wdata[7:0] == 8'hFF) m_id <= 1'b0;
      end
      if (fl_re && !re_d) begin
        if (rn < 8) rlog_a[rn] <= fl_addr;
        if (rn == 0) gap <= cyc - t_fall;
        rn <= rn + 1;
      end
    end
  end

  int n_chk = 0, n_bad = 0;

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic bit exp_known(input logic [15:0] mfr, input logic [15:0] dev);
    return (mfr[7:0] == 8'h01 || mfr[7:0] == 8'h89) && dev == 16'h0093;
  endfunction
  function automatic bit exp_mirror(input int mode);
    return mode == 1 || mode == 4;
  endfunction
  function automatic logic [7:0] exp_exit(input logic [15:0] mfr);
    return (mfr[7:0] == 8'h89) ? 8'hFF : 8'hF0;
  endfunction

  task automatic run_probe(input logic [15:0] mfr, input logic [15:0] dev,
                           input int mode, input bit busy_start);
    bit known, valid;
    int waited;
    @(negedge clk);
    m_mfr = mfr; m_dev = dev; m_alias = mode;
    clr = 1'b1;
    @(negedge clk);
    clr = 1'b0; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check(id_valid == 1'b0 && size_bytes == 0, "R9", "cleared after start",
          {63'd0, id_valid}, 64'd0);
    if (busy_start) begin
      repeat (40) @(negedge clk);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
    waited = 0;
    while (!done && waited < 5000) begin @(negedge clk); waited++; end
    check(done == 1'b1, "R8", "done reached", {63'd0, done}, 64'd1);
    known = exp_known(mfr, dev);
    valid = known && !exp_mirror(mode);
    check(id_valid == valid, valid ? "R5" : (known ? "R6" : "R4"), "id_valid",
          {63'd0, id_valid}, {63'd0, valid});
    check(vendor_class == (valid ? ((mfr[7:0] == 8'h89) ? 2'd2 : 2'd1) : 2'd0),
          "R5", "vendor_class", {62'd0, vendor_class},
          valid ? ((mfr[7:0] == 8'h89) ? 64'd2 : 64'd1) : 64'd0);
    check(size_bytes == (valid ? 32'd8388608 : 32'd0), "R4", "size_bytes",
          {32'd0, size_bytes}, valid ? 64'd8388608 : 64'd0);
    check(sect_count == (valid ? 8'd128 : 8'd0), "R4", "sect_count",
          {56'd0, sect_count}, valid ? 64'd128 : 64'd0);
    check(dev_code == dev, "R3", "dev_code", {48'd0, dev_code}, {48'd0, dev});
    check(wn == 4, "R7", "write count", wn, 4);
    check(wlog_a[0] == 23'h555 && wlog_d[0] == 16'h00AA &&
          wlog_a[1] == 23'h2AA && wlog_d[1] == 16'h0055 &&
          wlog_a[2] == 23'h555 && wlog_d[2] == 16'h0090,
          "R1", "entry sequence", {25'd0, wlog_a[2], wlog_d[2]}, {25'd0, 23'h555, 16'h0090});
    check(wlog_a[3] == '0 && wlog_d[3] == {8'h00, exp_exit(mfr)}, "R7", "exit command",
          {48'd0, wlog_d[3]}, {56'd0, exp_exit(mfr)});
    check(gap >= WAIT_CYC, "R2", "id wait", gap, WAIT_CYC);
    check(rn == (known ? 4 : 2), known ? "R6" : "R4", "read count", rn, known ? 4 : 2);
    check(rlog_a[0] == 23'd0 && rlog_a[1] == 23'd1, "R3", "id read offsets",
          {41'd0, rlog_a[1]}, 64'd1);
    if (known)
      check(rlog_a[2] == 23'h400000 && rlog_a[3] == 23'h400001, "R6",
            "alias offsets", {41'd0, rlog_a[3]}, 64'h400001);
    @(negedge clk);
    check(done == 1'b0, "R8", "done one cycle", {63'd0, done}, 64'd0);
    repeat (15) @(negedge clk);
    check(id_valid == valid && done == 1'b0, "R9", "descriptor held",
          {63'd0, id_valid}, {63'd0, valid});
    sect_sel = 7'd5;
    repeat (2) @(negedge clk);
    check(sect_base == (valid ? 32'h50000 : 32'd0), "R10", "sector 5 base",
          {32'd0, sect_base}, valid ? 64'h50000 : 64'd0);
    sect_sel = 7'd127;
    repeat (2) @(negedge clk);
    check(sect_base == (valid ? 32'h7F0000 : 32'd0), "R10", "sector 127 base",
          {32'd0, sect_base}, valid ? 64'h7F0000 : 64'd0);
  endtask

  initial begin
    #(2 * HALF * 150000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual running expected finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED));
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(done == 0 && id_valid == 0 && fl_we == 0 && fl_re == 0 && size_bytes == 0,
          "R8", "reset state", {63'd0, done | id_valid | fl_we | fl_re}, 64'd0);
    run_probe(16'h0001, 16'h0093, 0, 1'b0);   // R5 unlock family
    run_probe(16'h3C89, 16'h0093, 0, 1'b0);   // R3 R5 R7 status family, upper bits ignored
    run_probe(16'h0001, 16'h0093, 1, 1'b0);   // R6 exact mirror
    run_probe(16'h0089, 16'h0093, 4, 1'b0);   // R6 mirror differing only in upper bits
    run_probe(16'h0001, 16'h0093, 2, 1'b0);   // R6 device differs
    run_probe(16'h0001, 16'h0093, 3, 1'b0);   // R6 manufacturer differs
    run_probe(16'h0020, 16'h0093, 1, 1'b0);   // R4 unknown manufacturer
    run_probe(16'h0001, 16'h22C8, 1, 1'b0);   // R4 unknown device
    run_probe(16'h0001, 16'h0093, 0, 1'b1);   // R9 start during probe
    for (int i = 0; i < 10; i++) begin
      logic [15:0] mf, dv;
      int pick;
      pick = $urandom_range(0, 2);
      mf = {8'($urandom), (pick == 0) ? 8'h01 : (pick == 1) ? 8'h89 : 8'($urandom)};
      dv = ($urandom_range(0, 3) != 0) ? 16'h0093 : 16'($urandom);
      run_probe(mf, dv, $urandom_range(0, 4), 1'b0);
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule